// File: doc/BRIEF.md
# Flash Command Status Register

This block is the byte-wide status and command-start register of a flash memory controller. It sits at one address on a simple register bus. It holds a command-complete flag, three error flags and one read-only result bit. Software starts a flash command by writing one to the complete flag. The block turns that write into a single-cycle start pulse to the command engine, provided no blocking error is pending.

The controller feeds the block with these events: the end of reset initialisation, command completion with a result bit, access errors, protection errors and reads of the flash array. The block reports a busy level while the complete flag is low. Errors stay latched until software clears them by writing one to the flag. The complete flag starts at zero after reset and rises only when the controller reports that initialisation has ended.

Top module: `fcmd_status_reg`

## Requirements
- R1: Read data, returned combinationally while `bus_sel` is high, is laid out as: bit 7 complete flag, bit 6 read-collision flag, bit 5 access-error flag, bit 4 protection flag, bit 0 command result. Bits 3..1 always read 0 and writes to them, or to bit 0, change nothing. Read data is 0 while `bus_sel` is low, and writes with `bus_sel` low have no effect.
- R2: After reset the register reads 0x00 and `busy` is 1. The complete flag becomes 1 in the cycle after an `init_done` pulse.
- R3: A write with data bit 7 = 1 while the complete flag is 1 raises `launch` for exactly one cycle, in the cycle after the write. From that same cycle the complete flag reads 0 and `busy` is 1.
- R4: While the access-error or the protection flag is set, or while either error event arrives in the write cycle, a write with bit 7 = 1 produces no `launch` and the complete flag stays 1.
- R5: A write with bit 7 = 0, or a write with bit 7 = 1 while the complete flag is 0, produces no `launch` and leaves the complete flag unchanged.
- R6: Writing 1 to bit 6, 5 or 4 clears that flag in the next cycle. Writing 0 to a flag leaves it unchanged.
- R7: If an error event and a write-one clear of the same flag happen in the same cycle, the flag ends up set.
- R8: An `array_rd` while the complete flag is 0 sets the read-collision flag. An `array_rd` while the flag is 1 does not.
- R9: A `cmd_done` pulse while the complete flag is 0 sets the flag to 1 and copies `cmd_stat` into bit 0. A launch clears bit 0 to 0.
- R10: `acc_err_evt` sets the access-error flag and `prot_err_evt` sets the protection flag. Either event while the complete flag is 0 also sets the complete flag to 1, which ends the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register address selected |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| array_rd | input | 1 | Host read of the flash array this cycle |
| init_done | input | 1 | Pulse at the end of reset initialisation |
| cmd_done | input | 1 | Pulse when the running command finishes |
| cmd_stat | input | 1 | Result bit, valid with `cmd_done` |
| acc_err_evt | input | 1 | Access-error event pulse |
| prot_err_evt | input | 1 | Protection-violation event pulse |
| launch | output | 1 | Single-cycle command start pulse |
| busy | output | 1 | High while the complete flag is 0 |

## Verification
The bench writes a start request while each blocking flag is set, and again in the cycle where an error event arrives. A design that checks only the latched flags would start a command in that second case. It issues a clear in the same cycle as an error event: a design where the clear wins would lose the error. It reads the array both while busy and while idle, to catch a collision flag that ignores the busy state. It also reports an error during a running command, which must end the command, and repeats a start write while busy, which must not produce a second pulse.

// File: rtl/fcs_pkg.sv
`timescale 1ns/1ps
package fcs_pkg;
    localparam int DW       = 8;
    localparam int NERR     = 3;
    localparam int RSVD_W   = DW - NERR - 2;
    // error index = bit position minus ERR_BASE
    localparam int ERR_BASE  = 4;
    localparam int ERR_PROT  = 0;
    localparam int ERR_ACC   = 1;
    localparam int ERR_RDCOL = 2;
    localparam int BIT_DONE  = DW - 1;

    typedef struct packed {
        logic              done;
        logic [NERR-1:0]   err;
        logic [RSVD_W-1:0] rsvd;
        logic              stat;
    } stat_reg_t;

    function automatic logic [DW-1:0] pack_status(input logic done,
                                                  input logic [NERR-1:0] err,
                                                  input logic stat);
        stat_reg_t r;
        r.done = done;
        r.err  = err;
        r.rsvd = '0;
        r.stat = stat;
        return r;
    endfunction

    function automatic int err_pos(input int idx);
        return ERR_BASE + idx;
    endfunction
endpackage

// File: rtl/fcs_err_bank.sv
`timescale 1ns/1ps
module fcs_err_bank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic f_q;
        always_ff @(posedge clk) begin
            if (rst)             f_q <= 1'b0;
            else if (set_vec[i]) f_q <= 1'b1;
            else if (clr_vec[i]) f_q <= 1'b0;
        end
        assign flags[i] = f_q;

        // R7: a set in the same cycle as a clear must not be lost
        assert_set_wins_R7: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> f_q);
        // R6: a clear with no set takes the flag low
        assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
            (clr_vec[i] && !set_vec[i]) |=> !f_q);
    end
endmodule

// File: rtl/fcs_cmd_ctrl.sv
`timescale 1ns/1ps
module fcs_cmd_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic go_req,
    input  logic block,
    input  logic init_done,
    input  logic cmd_done,
    input  logic cmd_stat,
    input  logic viol,
    output logic done_q,
    output logic stat_q,
    output logic launch_q
);
    logic launch_now;
    assign launch_now = go_req && done_q && !block;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q   <= 1'b0;
            stat_q   <= 1'b0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= launch_now;
            if (launch_now) begin
                done_q <= 1'b0;
                stat_q <= 1'b0;
            end else begin
                if (init_done || cmd_done || viol) done_q <= 1'b1;
                if (cmd_done && !done_q)           stat_q <= cmd_stat;
            end
        end
    end

    // R3: start pulse lasts one cycle only
    assert_launch_single_R3: assert property (@(posedge clk) disable iff (rst)
        launch_q |=> !launch_q);
    // R4: a blocked request never starts a command
    assert_blocked_R4: assert property (@(posedge clk) disable iff (rst)
        (go_req && block) |=> !launch_q);
    // R5: no start while a command is running
    assert_no_relaunch_R5: assert property (@(posedge clk) disable iff (rst)
        !done_q |=> !launch_q);
    // R9: completion ends a running command
    assert_done_sets_R9: assert property (@(posedge clk) disable iff (rst)
        (cmd_done && !done_q) |=> done_q);
    // R10: an error during a command terminates it
    assert_viol_ends_R10: assert property (@(posedge clk) disable iff (rst)
        (viol && !done_q) |=> done_q);
endmodule

// File: rtl/fcmd_status_reg.sv
`timescale 1ns/1ps
module fcmd_status_reg
    import fcs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          array_rd,
    input  logic          init_done,
    input  logic          cmd_done,
    input  logic          cmd_stat,
    input  logic          acc_err_evt,
    input  logic          prot_err_evt,
    output logic          launch,
    output logic          busy
);
    logic            wr_hit;
    logic [NERR-1:0] set_vec, clr_vec, flags;
    logic            done_q, stat_q, block, viol;

    assign wr_hit = bus_sel && bus_wr;
    assign viol   = acc_err_evt || prot_err_evt;

    for (genvar i = 0; i < NERR; i++) begin : g_clr
        assign clr_vec[i] = wr_hit && bus_wdata[err_pos(i)];
    end

    always_comb begin
        set_vec            = '0;
        set_vec[ERR_RDCOL] = array_rd && !done_q;
        set_vec[ERR_ACC]   = acc_err_evt;
        set_vec[ERR_PROT]  = prot_err_evt;
    end

    assign block = flags[ERR_ACC] || flags[ERR_PROT] || viol;

    fcs_err_bank #(.N(NERR)) u_err (
        .clk     (clk),
        .rst     (rst),
        .set_vec (set_vec),
        .clr_vec (clr_vec),
        .flags   (flags)
    );

    fcs_cmd_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .go_req    (wr_hit && bus_wdata[BIT_DONE]),
        .block     (block),
        .init_done (init_done),
        .cmd_done  (cmd_done),
        .cmd_stat  (cmd_stat),
        .viol      (viol),
        .done_q    (done_q),
        .stat_q    (stat_q),
        .launch_q  (launch)
    );

    assign busy      = !done_q;
    assign bus_rdata = bus_sel ? pack_status(done_q, flags, stat_q) : '0;

    // R8: a read of the array during a command marks a collision
    assert_collision_R8: assert property (@(posedge clk) disable iff (rst)
        (array_rd && busy) |=> flags[ERR_RDCOL]);
    // R8: a read while idle never raises the collision flag
    assert_no_idle_collision_R8: assert property (@(posedge clk) disable iff (rst)
        (!flags[ERR_RDCOL] && !busy) |=> !flags[ERR_RDCOL]);
    // R3: a start pulse always coincides with a running command
    assert_launch_busy_R3: assert property (@(posedge clk) disable iff (rst)
        launch |-> busy);
endmodule

// File: tb/fcmd_status_reg_tb.sv
`timescale 1ns/1ps
module fcmd_status_reg_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b1, bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       array_rd = 1'b0, init_done = 1'b0, cmd_done = 1'b0, cmd_stat = 1'b0;
    logic       acc_err_evt = 1'b0, prot_err_evt = 1'b0;
    logic       launch, busy;
    int         n_chk = 0, n_fail = 0;

    always #10 clk = ~clk;

    fcmd_status_reg u_dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .array_rd(array_rd),
        .init_done(init_done), .cmd_done(cmd_done), .cmd_stat(cmd_stat),
        .acc_err_evt(acc_err_evt), .prot_err_evt(prot_err_evt),
        .launch(launch), .busy(busy));

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        bus_wr = 1'b1; bus_wdata = d;
        cyc();
        bus_wr = 1'b0; bus_wdata = 8'h00;
    endtask

    task automatic finish_cmd(input logic s);
        cmd_done = 1'b1; cmd_stat = s;
        cyc();
        cmd_done = 1'b0; cmd_stat = 1'b0;
    endtask

    task automatic t_reset_init();
        chk("R2 reset value", bus_rdata, 8'h00);
        chk("R2 busy after reset", {7'd0, busy}, 8'h01);
        init_done = 1'b1; cyc(); init_done = 1'b0;
        chk("R2 complete after init", bus_rdata, 8'h80);
        chk("R2 idle after init", {7'd0, busy}, 8'h00);
    endtask

    task automatic t_launch_done();
        wr(8'h80);
        chk("R3 launch pulse", {7'd0, launch}, 8'h01);
        chk("R3 flag low", bus_rdata, 8'h00);
        chk("R3 busy", {7'd0, busy}, 8'h01);
        cyc();
        chk("R3 pulse single cycle", {7'd0, launch}, 8'h00);
        wr(8'h80);
        chk("R5 no relaunch while busy", {7'd0, launch}, 8'h00);
        finish_cmd(1'b1);
        chk("R9 done with result 1", bus_rdata, 8'h81);
        wr(8'h80);
        chk("R9 launch clears result", bus_rdata, 8'h00);
        finish_cmd(1'b0);
        chk("R9 done with result 0", bus_rdata, 8'h80);
    endtask

    task automatic t_unused_bits();
        wr(8'h0F);
        chk("R5 bit7 zero no launch", {7'd0, launch}, 8'h00);
        chk("R1 reserved bits ignore writes", bus_rdata, 8'h80);
        bus_sel = 1'b0;
        #1 chk("R1 no data when unselected", bus_rdata, 8'h00);
        wr(8'h80);
        chk("R1 unselected write ignored", {7'd0, launch}, 8'h00);
        bus_sel = 1'b1;
        #1 chk("R1 still idle", bus_rdata, 8'h80);
    endtask

    task automatic t_collision();
        array_rd = 1'b1; cyc(); array_rd = 1'b0;
        chk("R8 idle read no collision", bus_rdata, 8'h80);
        wr(8'h80);
        array_rd = 1'b1; cyc(); array_rd = 1'b0;
        chk("R8 busy read collision", bus_rdata, 8'h40);
        finish_cmd(1'b0);
        chk("R8 collision persists", bus_rdata, 8'hC0);
        wr(8'h00);
        chk("R6 write zero keeps flag", bus_rdata, 8'hC0);
        wr(8'h40);
        chk("R6 clear collision", bus_rdata, 8'h80);
    endtask

    task automatic t_blocking();
        acc_err_evt = 1'b1; cyc(); acc_err_evt = 1'b0;
        chk("R10 access flag set", bus_rdata, 8'hA0);
        wr(8'h80);
        chk("R4 access blocks launch", {7'd0, launch}, 8'h00);
        chk("R4 complete stays", bus_rdata, 8'hA0);
        wr(8'h20);
        chk("R6 clear access", bus_rdata, 8'h80);
        prot_err_evt = 1'b1; cyc(); prot_err_evt = 1'b0;
        chk("R10 protection flag set", bus_rdata, 8'h90);
        wr(8'h80);
        chk("R4 protection blocks launch", {7'd0, launch}, 8'h00);
        wr(8'h10);
        chk("R6 clear protection", bus_rdata, 8'h80);
        acc_err_evt = 1'b1; wr(8'h80); acc_err_evt = 1'b0;
        chk("R4 same-cycle event blocks", {7'd0, launch}, 8'h00);
        chk("R4 flag and complete", bus_rdata, 8'hA0);
    endtask

    task automatic t_set_wins();
        acc_err_evt = 1'b1; wr(8'h20); acc_err_evt = 1'b0;
        chk("R7 set beats clear", bus_rdata, 8'hA0);
        wr(8'h20);
        chk("R7 later clear works", bus_rdata, 8'h80);
    endtask

    task automatic t_violation();
        wr(8'h80);
        chk("R3 launch before violation", {7'd0, launch}, 8'h01);
        prot_err_evt = 1'b1; cyc(); prot_err_evt = 1'b0;
        chk("R10 violation ends command", bus_rdata, 8'h90);
        chk("R10 not busy", {7'd0, busy}, 8'h00);
        wr(8'h10);
        chk("R10 cleared", bus_rdata, 8'h80);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        t_reset_init();
        t_launch_done();
        t_unused_bits();
        t_collision();
        t_blocking();
        t_set_wins();
        t_violation();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule